// File: doc/BRIEF.md
# Constant Result Register Elision Unit

This block keeps the constants 0 and 1 out of the physical register file of an out-of-order core. It sits at writeback. Each completing result is compared against 0 and 1. A result equal to either constant is never written into the storage array. Instead, the physical register that rename handed to that instruction is released. The destination is then remapped to one of two reserved tags that stand for the constants. The release and the remap appear together, one cycle after the writeback, as a single event. The scheduler broadcast and the rename map consume that event. Both lie outside this block.

On the read side, every read port first decodes its source tag. A reserved tag produces the constant at once, zero-extended to the datapath width, and raises a bypass flag; the array is not enabled for that port. An allocatable tag reads the array. The two reserved tags lie just above the allocatable range, so a free list that only holds allocatable tags can never hand them out.

Top module: `celide_unit`

## Requirements
- R1: A writeback whose data is exactly 0 produces, in the next cycle, `free_valid`=1 with `free_tag` equal to the writeback tag, and `remap_valid`=1 with `remap_old_tag` equal to the writeback tag and `remap_new_tag` equal to the zero tag, which is the value NUM_PREGS (32 with defaults).
- R2: A writeback whose data is exactly 1 produces the same release and remap in the next cycle, with `remap_new_tag` equal to the one tag, which is the value NUM_PREGS+1 (33 with defaults).
- R3: A writeback whose data is neither 0 nor 1 produces no release or remap. This includes 2, all-ones, and values whose low bit is 1 with upper bits set. Its data is stored and can be read back through its tag from the cycle after the writeback.
- R4: A constant writeback leaves the array untouched, so a read of that tag still returns the value the register held before.
- R5: A read of the zero tag returns 0 and a read of the one tag returns 1 in bit 0 with all other bits 0. Both raise the port's `rd_bypass` bit in the same cycle.
- R6: A read of an allocatable tag (below NUM_PREGS) returns the stored value with `rd_bypass`=0. A tag above the one tag returns 0 with `rd_bypass`=0.
- R7: Release and remap always occur in the same cycle, and in that cycle `free_tag` equals `remap_old_tag`. Back-to-back constant writebacks each produce their own event in consecutive cycles.
- R8: A synchronous active-high reset clears all events and all stored registers to 0.
- R9: A cycle with `wb_valid`=0 produces no event in the next cycle and changes no stored register.
- R10: The read ports are independent. Each decodes its own tag in the same cycle, whatever the other ports are given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | A result completes this cycle |
| wb_tag | input | TAG_W (6) | Physical tag assigned at rename |
| wb_data | input | DATA_W (64) | Result value |
| rd_tag | input | RD_PORTS*TAG_W (12) | Source tag of each read port |
| rd_data | output | RD_PORTS*DATA_W (128) | Operand value of each read port |
| rd_bypass | output | RD_PORTS (2) | Port served a constant without the array |
| free_valid | output | 1 | Release a physical register |
| free_tag | output | TAG_W (6) | Register being released |
| remap_valid | output | 1 | Destination remap event |
| remap_old_tag | output | TAG_W (6) | Tag being replaced |
| remap_new_tag | output | TAG_W (6) | Reserved constant tag |

## Verification
The assertions assume that a writeback tag always lies in the allocatable range. Rename never assigns a reserved tag as a destination, so this holds at the block's input, and one assertion states it as an input check. The stimulus writes only to tags 0 through 31. It sends reserved and out-of-range tags only on the read ports, where decoding them is the behaviour under test. Each writeback is held for a single cycle, so every event seen at the outputs can be traced to exactly one writeback.

// File: rtl/celide_pkg.sv
package celide_pkg;

    parameter int DATA_W    = 64;
    parameter int NUM_PREGS = 32;
    parameter int RD_PORTS  = 2;

    localparam int IDX_W = $clog2(NUM_PREGS);
    localparam int TAG_W = IDX_W + 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam tag_t ZERO_TAG = tag_t'(NUM_PREGS);
    localparam tag_t ONE_TAG  = tag_t'(NUM_PREGS + 1);

    typedef enum logic [1:0] {
        K_OTHER = 2'd0,
        K_ZERO  = 2'd1,
        K_ONE   = 2'd2
    } kind_e;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } wb_evt_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } rel_evt_t;

    typedef struct packed {
        logic valid;
        tag_t old_tag;
        tag_t new_tag;
    } remap_evt_t;

    function automatic kind_e classify(input data_t d);
        if (d == '0)
            return K_ZERO;
        else if (d == data_t'(1))
            return K_ONE;
        return K_OTHER;
    endfunction

    function automatic tag_t kind_tag(input kind_e k);
        return (k == K_ONE) ? ONE_TAG : ZERO_TAG;
    endfunction

    function automatic logic is_alloc(input tag_t t);
        return t < tag_t'(NUM_PREGS);
    endfunction

endpackage

// File: rtl/celide_wb_classify.sv
module celide_wb_classify
    import celide_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wb_evt_t    wb,
    output rel_evt_t   rel,
    output remap_evt_t remap,
    output logic       we,
    output idx_t       widx,
    output data_t      wdata
);

    kind_e kind;
    logic  hit;

    always_comb begin
        kind  = classify(wb.data);
        hit   = wb.valid && (kind != K_OTHER);
        we    = wb.valid && (kind == K_OTHER);
        widx  = wb.tag[IDX_W-1:0];
        wdata = wb.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel   <= '0;
            remap <= '0;
        end else begin
            rel.valid     <= hit;
            rel.tag       <= hit ? wb.tag : '0;
            remap.valid   <= hit;
            remap.old_tag <= hit ? wb.tag : '0;
            remap.new_tag <= hit ? kind_tag(kind) : '0;
        end
    end

    // input check: writebacks only target allocatable tags
    wb_tag_range_chk: assert property (@(posedge clk) disable iff (rst)
        wb.valid |-> is_alloc(wb.tag));

    // R1
    zero_remap_chk: assert property (@(posedge clk) disable iff (rst)
        (wb.valid && wb.data == '0) |=>
            (remap.valid && rel.valid && remap.new_tag == ZERO_TAG
             && remap.old_tag == $past(wb.tag) && rel.tag == $past(wb.tag)));

    // R2
    one_remap_chk: assert property (@(posedge clk) disable iff (rst)
        (wb.valid && wb.data == data_t'(1)) |=>
            (remap.valid && rel.valid && remap.new_tag == ONE_TAG
             && remap.old_tag == $past(wb.tag)));

    // R3
    other_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (wb.valid && wb.data > data_t'(1)) |=> (!remap.valid && !rel.valid));

    // R9
    idle_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        !wb.valid |=> (!remap.valid && !rel.valid));

    // R7
    pair_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rel.valid || remap.valid) |-> (rel.valid && remap.valid && rel.tag == remap.old_tag));

endmodule

// File: rtl/celide_store.sv
module celide_store
    import celide_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  idx_t                       widx,
    input  data_t                      wdata,
    input  logic  [RD_PORTS-1:0]       rd_en,
    input  idx_t  [RD_PORTS-1:0]       rd_idx,
    output data_t [RD_PORTS-1:0]       rd_raw
);

    logic [NUM_PREGS-1:0][DATA_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst)
            mem <= '0;
        else if (we)
            mem[widx] <= wdata;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_raw[p] = rd_en[p] ? mem[rd_idx[p]] : '0;
    end

    // R4
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));

    // R3
    store_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/celide_rd_port.sv
module celide_rd_port
    import celide_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  tag,
    input  data_t raw,
    output logic  arr_en,
    output idx_t  idx,
    output data_t data,
    output logic  bypass
);

    logic is_zero;
    logic is_one;

    always_comb begin
        is_zero = (tag == ZERO_TAG);
        is_one  = (tag == ONE_TAG);
        bypass  = is_zero || is_one;
        arr_en  = is_alloc(tag);
        idx     = tag[IDX_W-1:0];
        if (is_one)
            data = data_t'(1);
        else if (arr_en)
            data = raw;
        else
            data = '0;
    end

    // R5
    const_read_chk: assert property (@(posedge clk) disable iff (rst)
        (tag == ONE_TAG || tag == ZERO_TAG) |-> (!arr_en && data[DATA_W-1:1] == '0));

    // R6
    alloc_read_chk: assert property (@(posedge clk) disable iff (rst)
        arr_en |-> (!bypass && data == raw));

endmodule

// File: rtl/celide_unit.sv
module celide_unit
    import celide_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wb_valid,
    input  logic [TAG_W-1:0]                 wb_tag,
    input  logic [DATA_W-1:0]                wb_data,
    input  logic [RD_PORTS-1:0][TAG_W-1:0]   rd_tag,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data,
    output logic [RD_PORTS-1:0]              rd_bypass,
    output logic                             free_valid,
    output logic [TAG_W-1:0]                 free_tag,
    output logic                             remap_valid,
    output logic [TAG_W-1:0]                 remap_old_tag,
    output logic [TAG_W-1:0]                 remap_new_tag
);

    wb_evt_t    wb;
    rel_evt_t   rel;
    remap_evt_t remap;
    logic       we;
    idx_t       widx;
    data_t      wdata;

    logic  [RD_PORTS-1:0] arr_en;
    idx_t  [RD_PORTS-1:0] arr_idx;
    data_t [RD_PORTS-1:0] arr_raw;

    assign wb.valid = wb_valid;
    assign wb.tag   = wb_tag;
    assign wb.data  = wb_data;

    celide_wb_classify i_classify (
        .clk   (clk),
        .rst   (rst),
        .wb    (wb),
        .rel   (rel),
        .remap (remap),
        .we    (we),
        .widx  (widx),
        .wdata (wdata)
    );

    celide_store i_store (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .widx   (widx),
        .wdata  (wdata),
        .rd_en  (arr_en),
        .rd_idx (arr_idx),
        .rd_raw (arr_raw)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        celide_rd_port i_port (
            .clk    (clk),
            .rst    (rst),
            .tag    (rd_tag[p]),
            .raw    (arr_raw[p]),
            .arr_en (arr_en[p]),
            .idx    (arr_idx[p]),
            .data   (rd_data[p]),
            .bypass (rd_bypass[p])
        );
    end

    assign free_valid    = rel.valid;
    assign free_tag      = rel.tag;
    assign remap_valid   = remap.valid;
    assign remap_old_tag = remap.old_tag;
    assign remap_new_tag = remap.new_tag;

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!free_valid && !remap_valid));

endmodule

// File: tb/test_celide_unit.sv
`timescale 1ns/1ps
module test_celide_unit;
    import celide_pkg::*;

    logic                             clk = 1'b0;
    logic                             rst = 1'b1;
    logic                             wb_valid = 1'b0;
    logic [TAG_W-1:0]                 wb_tag = '0;
    logic [DATA_W-1:0]                wb_data = '0;
    logic [RD_PORTS-1:0][TAG_W-1:0]   rd_tag = '0;
    logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data;
    logic [RD_PORTS-1:0]              rd_bypass;
    logic                             free_valid;
    logic [TAG_W-1:0]                 free_tag;
    logic                             remap_valid;
    logic [TAG_W-1:0]                 remap_old_tag;
    logic [TAG_W-1:0]                 remap_new_tag;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;
    logic [63:0] model [32];

    localparam logic [5:0] ZT = 6'd32;
    localparam logic [5:0] OT = 6'd33;
    localparam int NV = 10;
    localparam logic [5:0]  VT [NV] = '{6'd3, 6'd3, 6'd7, 6'd7, 6'd9, 6'd9,
                                        6'd0, 6'd31, 6'd31, 6'd0};
    localparam logic [63:0] VD [NV] = '{64'h1234_5678_9abc_def0, 64'h0,
                                        64'h1, 64'h2, 64'hffff_ffff_ffff_ffff,
                                        64'h1_0000_0001, 64'h0, 64'h1,
                                        64'h8000_0000_0000_0000, 64'h5};

    always #2.5 clk = ~clk;

    celide_unit i_celide_unit (
        .clk           (clk),
        .rst           (rst),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .wb_data       (wb_data),
        .rd_tag        (rd_tag),
        .rd_data       (rd_data),
        .rd_bypass     (rd_bypass),
        .free_valid    (free_valid),
        .free_tag      (free_tag),
        .remap_valid   (remap_valid),
        .remap_old_tag (remap_old_tag),
        .remap_new_tag (remap_new_tag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one writeback; events checked one cycle later
    task automatic do_wb(input string req, input logic [5:0] t, input logic [63:0] d);
        logic is_c;
        is_c = (d == 64'h0) || (d == 64'h1);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = t; wb_data = d;
        @(negedge clk);
        wb_valid = 1'b0;
        chk({req, " free_valid"},  64'(free_valid),  64'(is_c));
        chk({req, " remap_valid"}, 64'(remap_valid), 64'(is_c));
        if (is_c) begin
            chk({req, " free_tag"},      64'(free_tag),      64'(t));
            chk({req, " remap_old_tag"}, 64'(remap_old_tag), 64'(t));
            chk({req, " remap_new_tag"}, 64'(remap_new_tag), (d == 64'h0) ? 64'(ZT) : 64'(OT));
        end else begin
            model[t] = d;
        end
        rd_tag[0] = t; rd_tag[1] = t;
        #1;
        chk({req, " R6 port0 data"}, rd_data[0], model[t]);
        chk({req, " R6 port1 data"}, rd_data[1], model[t]);
        chk({req, " R6 bypass"}, 64'(rd_bypass), 64'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        rd_tag[0] = 6'd4; rd_tag[1] = 6'd31;
        #1;
        chk("R8 free_valid", 64'(free_valid), 64'h0);
        chk("R8 remap_valid", 64'(remap_valid), 64'h0);
        chk("R8 port0 data", rd_data[0], 64'h0);
        chk("R8 port1 data", rd_data[1], 64'h0);

        // vector table; R1 R2 R3 R4 covered by expected values
        for (int v = 0; v < NV; v++)
            do_wb("R1/R2/R3/R4 vec", VT[v], VD[v]);

        // R4 explicit: tag 3 held old value after zero write
        rd_tag[0] = 6'd3;
        #1;
        chk("R4 tag3 kept", rd_data[0], 64'h1234_5678_9abc_def0);

        // R5 R10 reserved tags on both ports at once
        @(negedge clk);
        rd_tag[0] = ZT; rd_tag[1] = OT;
        #1;
        chk("R5 zero tag data", rd_data[0], 64'h0);
        chk("R5 one tag data", rd_data[1], 64'h1);
        chk("R5 R10 bypass both", 64'(rd_bypass), 64'h3);
        rd_tag[0] = 6'd9; rd_tag[1] = ZT;
        #1;
        chk("R10 port0 array", rd_data[0], 64'h1_0000_0001);
        chk("R10 port0 bypass", 64'(rd_bypass[0]), 64'h0);
        chk("R10 port1 bypass", 64'(rd_bypass[1]), 64'h1);
        // R6 out-of-range tag
        rd_tag[0] = 6'd40;
        #1;
        chk("R6 invalid tag data", rd_data[0], 64'h0);
        chk("R6 invalid tag bypass", 64'(rd_bypass[0]), 64'h0);

        // R9 idle cycle: no events, storage unchanged
        @(negedge clk);
        wb_tag = 6'd9; wb_data = 64'h0;
        @(negedge clk);
        chk("R9 no free", 64'(free_valid), 64'h0);
        chk("R9 no remap", 64'(remap_valid), 64'h0);
        rd_tag[0] = 6'd9;
        #1;
        chk("R9 tag9 kept", rd_data[0], 64'h1_0000_0001);

        // R7 back-to-back constants
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = 6'd12; wb_data = 64'h0;
        @(negedge clk);
        wb_tag = 6'd13; wb_data = 64'h1;
        chk("R7 first free_tag", 64'(free_tag), 64'd12);
        chk("R7 first new_tag", 64'(remap_new_tag), 64'(ZT));
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R7 second free_valid", 64'(free_valid), 64'h1);
        chk("R7 second old_tag", 64'(remap_old_tag), 64'd13);
        chk("R7 second new_tag", 64'(remap_new_tag), 64'(OT));
        @(negedge clk);
        chk("R7 quiet after", 64'(remap_valid), 64'h0);

        // R8 reset clears storage
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_tag[0] = 6'd7; rd_tag[1] = 6'd31;
        #1;
        chk("R8 tag7 cleared", rd_data[0], 64'h0);
        chk("R8 tag31 cleared", rd_data[1], 64'h0);
        chk("R8 no event", 64'(free_valid), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule